// File: doc/BRIEF.md
# 8-bit Compare Timer

This block is an 8-bit timer/counter with a single compare register and a driver for one output-compare pin. It moves one step for each count-enable strobe, which comes from a separate prescaler. Between strobes the count holds. A strobe every clock gives an undivided count. A strobe every Nth clock makes each count value last N clocks.

Two control inputs select one of four counting behaviours. With PWM mode off, the counter runs up and rolls over at 0xFF. If the clear-on-match bit is also set, it returns to zero on the strobe after it has shown the compare value. With PWM mode on, the same clear-on-match bit chooses between two shapes. When the bit is clear, the counter is a triangle that turns around at both ends. When the bit is set, it is a sawtooth that wraps from 0xFF to 0x00.

Whenever a strobe brings the count to the compare value, the block raises a one-clock match flag. On that same edge it applies the selected output action to the pin register. The compare logic takes over the pin only when the direction bit is set and the output mode is not the disconnected one.

Top module: `cmp_timer8`

## Requirements
- R1: The 2-bit output mode `oc_mode` acts on the pin register at a match as follows: 2'b00 leaves it unchanged, 2'b01 inverts it, 2'b10 loads 0 and 2'b11 loads 1.
- R2: `oc_own` is high exactly when `pin_dir` is 1 and `oc_mode` is not 2'b00. `oc_pin` shows the pin register while `oc_own` is high and is 0 otherwise.
- R3: With `pwm_sel`=0 and `clr_on_match`=1, a strobe taken while the count equals `cmp_val` loads 0x00. With a strobe on every clock and compare value C, the count reads C-1, C, 0, 1.
- R4: When strobes are N clocks apart, under the settings of R3, the value C stays on `count` for N clocks before the count returns to 0.
- R5: With `pwm_sel`=0 and `clr_on_match`=0, the compare value has no effect on counting. Each strobe adds one, and 0xFF rolls over to 0x00.
- R6: With `pwm_sel`=1 and `clr_on_match`=0, the counter counts up to 0xFF and then down to 0x00, and repeats. Each end value appears on a single strobe before the direction reverses. Out of reset the counter counts up.
- R7: With `pwm_sel`=1 and `clr_on_match`=1, each strobe adds one, and the count wraps from 0xFF to 0x00.
- R8: `count` changes only on clocks where `cnt_en` is high.
- R9: `match` is high for exactly one clock, the clock in which a strobe has just made `count` equal to `cmp_val`. The pin register changes only on that same edge.
- R10: A low `rst_n` clears the count, the pin register and the match flag, and sets the direction to up, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously upstream |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| cmp_val | input | 8 | Compare value |
| clr_on_match | input | 1 | Clear on match (PWM off) or sawtooth select (PWM on) |
| oc_mode | input | 2 | Output action applied at a match |
| pwm_sel | input | 1 | PWM counting mode select |
| pin_dir | input | 1 | Direction bit of the pin; 1 lets the compare logic drive it |
| count | output | 8 | Current count value |
| match | output | 1 | One-clock compare-match pulse |
| oc_pin | output | 1 | Compare output pin value |
| oc_own | output | 1 | High while the compare logic drives the pin |

## Verification
On every clock, properties check the following step rules:
- the clear-to-zero step and the free-running increment;
- the turnaround at both ends of the triangle and the sawtooth wrap;
- that the count holds between strobes;
- the set, clear and invert actions on the pin register, and that it holds when there is no match;
- that the match flag agrees with the compare value.

Some behaviours span many strobes, and only the directed scenarios can show them. These are how long C stays on the count at a divided strobe rate, that each end of the triangle appears only once per turnaround, and how the pin ownership gating responds to the direction bit and mode. The scenarios also check the asynchronous clear in the middle of a run.

// File: rtl/ct8_pkg.sv
package ct8_pkg;

  typedef enum logic [1:0] {
    OC_OFF    = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_mode_e;

  typedef enum logic [1:0] {
    CM_FREE  = 2'b00,
    CM_CLEAR = 2'b01,
    CM_TRI   = 2'b10,
    CM_SAW   = 2'b11
  } cnt_mode_e;

endpackage

// File: rtl/ct8_counter.sv
module ct8_counter
  import ct8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             pwm_sel,
  input  logic             clr_on_match,
  input  logic [WIDTH-1:0] cmp_val,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_nxt
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnt_mode_e        mode;
  logic             down_q, down_d;
  logic [WIDTH-1:0] cnt_d;

  assign mode = cnt_mode_e'({pwm_sel, clr_on_match});

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (cnt_en) begin
      unique case (mode)
        CM_FREE:  cnt_d = cnt_q + ONE;
        CM_CLEAR: cnt_d = (cnt_q == cmp_val) ? '0 : cnt_q + ONE;
        CM_SAW:   cnt_d = cnt_q + ONE;
        CM_TRI: begin
          if (!down_q) begin
            if (cnt_q == TOP) begin
              down_d = 1'b1;
              cnt_d  = TOP - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              down_d = 1'b0;
              cnt_d  = ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign cnt_nxt = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  // R3
  clr_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !pwm_sel && clr_on_match && cnt_q == cmp_val) |=> (cnt_q == '0));

  // R5
  free_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !pwm_sel && !clr_on_match) |=> (cnt_q == $past(cnt_q) + ONE));

  // R6
  tri_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pwm_sel && !clr_on_match && cnt_q == TOP) |=> (cnt_q == TOP - ONE));

  // R6
  tri_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pwm_sel && !clr_on_match && cnt_q == '0) |=> (cnt_q == ONE));

  // R7
  saw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pwm_sel && clr_on_match && cnt_q == TOP) |=> (cnt_q == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

endmodule

// File: rtl/ct8_match.sv
module ct8_match #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic [WIDTH-1:0] cmp_val,
  output logic             hit,
  output logic             flag_q
);

  assign hit = cnt_en && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit;
  end

  // R9
  flag_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> $past(cnt_en));

endmodule

// File: rtl/ct8_outdrv.sv
module ct8_outdrv
  import ct8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [1:0] out_mode,
  input  logic       pin_dir,
  output logic       oc_pin,
  output logic       oc_own
);

  oc_mode_e mode;
  logic     oc_q, oc_d;

  assign mode = oc_mode_e'(out_mode);

  always_comb begin
    oc_d = oc_q;
    if (hit) begin
      unique case (mode)
        OC_OFF:    oc_d = oc_q;
        OC_TOGGLE: oc_d = ~oc_q;
        OC_CLEAR:  oc_d = 1'b0;
        OC_SET:    oc_d = 1'b1;
        default:   oc_d = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assign oc_own = pin_dir && (mode != OC_OFF);
  assign oc_pin = oc_own & oc_q;

  // R1
  set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && out_mode == 2'b11) |=> oc_q);

  // R1
  clear_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && out_mode == 2'b10) |=> !oc_q);

  // R1
  toggle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && out_mode == 2'b01) |=> (oc_q != $past(oc_q)));

  // R9
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || out_mode == 2'b00) |=> $stable(oc_q));

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic             clr_on_match,
  input  logic [1:0]       oc_mode,
  input  logic             pwm_sel,
  input  logic             pin_dir,
  output logic [WIDTH-1:0] count,
  output logic             match,
  output logic             oc_pin,
  output logic             oc_own
);

  logic [WIDTH-1:0] cnt_nxt;
  logic             hit;

  ct8_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .pwm_sel      (pwm_sel),
    .clr_on_match (clr_on_match),
    .cmp_val      (cmp_val),
    .cnt_q        (count),
    .cnt_nxt      (cnt_nxt)
  );

  ct8_match #(.WIDTH(WIDTH)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_nxt (cnt_nxt),
    .cmp_val (cmp_val),
    .hit     (hit),
    .flag_q  (match)
  );

  ct8_outdrv u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .out_mode (oc_mode),
    .pin_dir  (pin_dir),
    .oc_pin   (oc_pin),
    .oc_own   (oc_own)
  );

  // R9
  flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $stable(cmp_val)) |-> (count == cmp_val));

endmodule

// File: tb/sim_cmp_timer8.sv
module sim_cmp_timer8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic [7:0] cmp_val;
  logic       clr_on_match;
  logic [1:0] oc_mode;
  logic       pwm_sel;
  logic       pin_dir;
  logic [7:0] count;
  logic       match;
  logic       oc_pin;
  logic       oc_own;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // independent expectation state, built from the requirements
  logic [7:0] m_cnt;
  logic       m_down;
  logic       m_oc;
  logic       m_flag;

  always #10 clk = ~clk;

  cmp_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cmp_val(cmp_val),
    .clr_on_match(clr_on_match), .oc_mode(oc_mode), .pwm_sel(pwm_sel),
    .pin_dir(pin_dir), .count(count), .match(match), .oc_pin(oc_pin),
    .oc_own(oc_own)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic en);
    logic [7:0] nx;
    nx = m_cnt;
    if (en) begin
      if (!pwm_sel) begin
        if (clr_on_match && m_cnt == cmp_val) nx = 8'h00;
        else nx = m_cnt + 8'd1;
      end else if (clr_on_match) begin
        nx = m_cnt + 8'd1;
      end else if (!m_down) begin
        if (m_cnt == 8'hFF) begin m_down = 1'b1; nx = 8'hFE; end
        else nx = m_cnt + 8'd1;
      end else begin
        if (m_cnt == 8'h00) begin m_down = 1'b0; nx = 8'h01; end
        else nx = m_cnt - 8'd1;
      end
    end
    m_flag = en && (nx == cmp_val);
    if (m_flag) begin
      if (oc_mode == 2'b01) m_oc = ~m_oc;
      else if (oc_mode == 2'b10) m_oc = 1'b0;
      else if (oc_mode == 2'b11) m_oc = 1'b1;
    end
    m_cnt = nx;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic en, input string tag);
    logic own_e;
    cnt_en = en;
    model_step(en);
    @(posedge clk);
    @(negedge clk);
    own_e = pin_dir && (oc_mode != 2'b00);
    chk(tag, "count", 32'(count), 32'(m_cnt));
    chk(tag, "match", 32'(match), 32'(m_flag));
    chk(tag, "oc_own", 32'(oc_own), 32'(own_e));
    chk(tag, "oc_pin", 32'(oc_pin), 32'(own_e & m_oc));
  endtask

  task automatic do_reset();
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    m_cnt = 8'h00; m_down = 1'b0; m_oc = 1'b0; m_flag = 1'b0;
    @(negedge clk);
  endtask

  // R10: reset values, then an asynchronous clear mid-run
  task automatic t_reset();
    cmp_val = 8'd40; clr_on_match = 1'b0; pwm_sel = 1'b0;
    oc_mode = 2'b11; pin_dir = 1'b1;
    do_reset();
    chk("R10", "count after reset", 32'(count), 32'h0);
    chk("R10", "match after reset", 32'(match), 32'h0);
    chk("R10", "pin after reset", 32'(oc_pin), 32'h0);
    for (int i = 0; i < 45; i++) step(1'b1, "R10");
    chk("R10", "pin set before clear", 32'(oc_pin), 32'h1);
    #3 rst_n = 1'b0;
    #2;
    chk("R10", "count async clear", 32'(count), 32'h0);
    chk("R10", "pin async clear", 32'(oc_pin), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 8'h00; m_down = 1'b0; m_oc = 1'b0; m_flag = 1'b0;
  endtask

  // R3: undivided clear on match, C = 5
  task automatic t_clear_div1();
    cmp_val = 8'd5; clr_on_match = 1'b1; pwm_sel = 1'b0;
    oc_mode = 2'b00; pin_dir = 1'b0;
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, "R3");
    chk("R3", "count reaches C", 32'(count), 32'd5);
    chk("R9", "match with C", 32'(match), 32'h1);
    step(1'b1, "R3");
    chk("R3", "count cleared", 32'(count), 32'd0);
    chk("R9", "match one clock", 32'(match), 32'h0);
    step(1'b1, "R3");
    chk("R3", "count after clear", 32'(count), 32'd1);
    for (int i = 0; i < 20; i++) step(1'b1, "R3");
  endtask

  // R4: strobe every 8 clocks, C = 3 held for 8 clocks
  task automatic t_clear_div8();
    int run;
    int first_run;
    bit seen_zero;
    cmp_val = 8'd3; clr_on_match = 1'b1; pwm_sel = 1'b0;
    oc_mode = 2'b00; pin_dir = 1'b0;
    do_reset();
    run = 0; first_run = -1; seen_zero = 1'b0;
    for (int i = 0; i < 80; i++) begin
      step((i % 8) == 0, "R4");
      if (count == 8'd3) run++;
      else if (run > 0 && first_run < 0) begin
        first_run = run;
        seen_zero = (count == 8'd0);
      end
    end
    chk("R4", "clocks holding C", 32'(first_run), 32'd8);
    chk("R4", "value after C", 32'(seen_zero), 32'h1);
  endtask

  // R5: no clear when disabled, full roll-over
  task automatic t_free();
    cmp_val = 8'd5; clr_on_match = 1'b0; pwm_sel = 1'b0;
    oc_mode = 2'b01; pin_dir = 1'b1;
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, "R5");
    chk("R5", "count passes C", 32'(count), 32'd6);
    for (int i = 0; i < 260; i++) step(1'b1, "R5");
    chk("R5", "count after roll-over", 32'(count), 32'd10);
  endtask

  // R6: triangle, each end once
  task automatic t_updown();
    int n_top;
    int n_bot;
    cmp_val = 8'd200; clr_on_match = 1'b0; pwm_sel = 1'b1;
    oc_mode = 2'b01; pin_dir = 1'b1;
    do_reset();
    n_top = 0; n_bot = 0;
    for (int i = 0; i < 520; i++) begin
      step(1'b1, "R6");
      if (count == 8'hFF) n_top++;
      if (count == 8'h00) n_bot++;
    end
    chk("R6", "samples at top", 32'(n_top), 32'd1);
    chk("R6", "samples at bottom", 32'(n_bot), 32'd1);
    chk("R6", "count after 520 strobes", 32'(count), 32'd10);
  endtask

  // R7: sawtooth wrap
  task automatic t_wrap();
    cmp_val = 8'd2; clr_on_match = 1'b1; pwm_sel = 1'b1;
    oc_mode = 2'b10; pin_dir = 1'b1;
    do_reset();
    for (int i = 0; i < 255; i++) step(1'b1, "R7");
    chk("R7", "count at top", 32'(count), 32'hFF);
    step(1'b1, "R7");
    chk("R7", "count wraps", 32'(count), 32'h00);
    for (int i = 0; i < 10; i++) step(1'b1, "R7");
  endtask

  // R1 and R2: output actions and pin ownership
  task automatic t_outmodes();
    cmp_val = 8'd2; clr_on_match = 1'b1; pwm_sel = 1'b0;
    oc_mode = 2'b01; pin_dir = 1'b1;
    do_reset();
    for (int i = 0; i < 12; i++) step(1'b1, "R1");
    oc_mode = 2'b11;
    for (int i = 0; i < 6; i++) step(1'b1, "R1");
    chk("R1", "pin set", 32'(oc_pin), 32'h1);
    oc_mode = 2'b10;
    for (int i = 0; i < 6; i++) step(1'b1, "R1");
    chk("R1", "pin cleared", 32'(oc_pin), 32'h0);
    oc_mode = 2'b11;
    for (int i = 0; i < 6; i++) step(1'b1, "R1");
    pin_dir = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, "R2");
    chk("R2", "pin released by dir", 32'(oc_pin), 32'h0);
    chk("R2", "own low by dir", 32'(oc_own), 32'h0);
    pin_dir = 1'b1; oc_mode = 2'b00;
    for (int i = 0; i < 4; i++) step(1'b1, "R2");
    chk("R2", "own low when off", 32'(oc_own), 32'h0);
    oc_mode = 2'b11;
    #1;
    chk("R2", "pin kept through off", 32'(oc_pin), 32'h1);
  endtask

  // R8: count only moves on strobes
  task automatic t_hold();
    cmp_val = 8'd9; clr_on_match = 1'b1; pwm_sel = 1'b0;
    oc_mode = 2'b01; pin_dir = 1'b1;
    do_reset();
    for (int i = 0; i < 60; i++) step((i % 3) == 1, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, "R8");
    chk("R8", "count after 20 strobes", 32'(count), 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; cmp_val = '0; clr_on_match = 1'b0;
    oc_mode = 2'b00; pwm_sel = 1'b0; pin_dir = 1'b0;
    @(negedge clk);
    t_reset();
    t_clear_div1();
    t_clear_div8();
    t_free();
    t_updown();
    t_wrap();
    t_outmodes();
    t_hold();
    done = 1'b1;
    summary();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
    end
  end

endmodule